// File: doc/BRIEF.md
# Integer Add-Subtract Execution Unit

This block is the 32-bit integer add/subtract stage of a processor datapath. Each cycle it takes an operation code, a first operand (which may be the program counter), a second operand that is either an already shifted register value or a 12-bit immediate, the current carry flag and a flag-update enable. It produces a registered 32-bit result and a registered set of negative, zero, carry and overflow flags.

Every operation goes through a single adder as `x + y + cin`. Subtractions invert one adder input and supply the carry-in, so a carry out of 1 means that no borrow occurred. This lets the carry-chained variants build multiword sums and differences one word at a time, starting with the low word. When the first operand is the program counter, its two low bits are cleared before the arithmetic and the flags are never written.

Decoding, operand shifting, the register file and condition evaluation all sit outside this block.

Top module: `addsub_unit`

## Requirements
- R1: With `op_sel`=0 (add), `result_q` equals first operand plus second operand modulo 2^32, one clock edge after the inputs are presented.
- R2: With `op_sel`=1 (add with carry), the result is first operand plus second operand plus `carry_in`.
- R3: With `op_sel`=2 (subtract), the result is first operand minus second operand, and the carry flag is 1 exactly when no borrow occurs (first operand >= second, unsigned).
- R4: With `op_sel`=3 (subtract with carry), the result is first operand minus second operand, minus one more when `carry_in` is 0. The carry flag is 1 when `{0,A} >= {0,B} + !carry_in`.
- R5: With `op_sel`=4 (reverse subtract), the result is second operand minus first operand, and the carry flag is 1 when second >= first (unsigned).
- R6: When `use_imm`=1 and `op_sel` is 0 or 2, the second operand is `imm12` zero-extended to 32 bits. For any other `op_sel`, `use_imm` is ignored and `reg_opnd` is used.
- R7: When `set_flags`=0, the four flag outputs keep their previous values.
- R8: When `base_is_pc`=1, bits [1:0] of the first operand are treated as 00, and the flags keep their values even if `set_flags`=1.
- R9: On a flag update, `flag_n` equals bit 31 of the result and `flag_z` is 1 exactly when the result is zero.
- R10: On a flag update, `flag_c` is the carry out of the 32-bit adder, and `flag_v` is 1 when the result lies outside the signed 32-bit range of the exact signed operation.
- R11: A synchronous active-high `rst` clears `result_q` and all four flags to 0.
- R12: Feeding `flag_c` back as `carry_in` gives a correct 64-bit chain: add followed by add-with-carry, and subtract followed by subtract-with-carry.
- R13: The unused codes 5, 6 and 7 of `op_sel` behave as add.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| op_sel | input | 3 | Operation: 0 add, 1 add+carry, 2 sub, 3 sub+carry, 4 reverse sub |
| base_val | input | 32 | First operand |
| base_is_pc | input | 1 | First operand is the program counter |
| reg_opnd | input | 32 | Pre-shifted register second operand |
| imm12 | input | 12 | Unsigned immediate second operand |
| use_imm | input | 1 | Select immediate (add and sub only) |
| carry_in | input | 1 | Incoming carry flag |
| set_flags | input | 1 | Write flags this cycle |
| result_q | output | 32 | Registered result |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry / not-borrow flag |
| flag_v | output | 1 | Signed overflow flag |

## Verification
A table of operand pairs drives every operation with both carry-in values. The table includes pairs around 0, 1, 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF. These pairs separate the carry-out from signed overflow and expose an off-by-one in the borrow handling of subtract-with-carry. Random pairs then catch slips in the operand order, most visibly in reverse subtract. Directed cases cover the immediate path with nonzero low bits, an immediate applied to an operation that must ignore it, an unaligned program-counter base under a flag-write request, held flags, and 64-bit add and subtract chains whose low word produces or consumes a carry.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 3'd0,
        OP_ADC = 3'd1,
        OP_SUB = 3'd2,
        OP_SBC = 3'd3,
        OP_RSB = 3'd4
    } op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;
endpackage

// File: rtl/addsub_operand_prep.sv
module addsub_operand_prep
    import addsub_pkg::*;
#(
    parameter int W     = 32,
    parameter int IMM_W = 12
) (
    input  logic [OP_W-1:0]  op_sel,
    input  logic [W-1:0]     base_val,
    input  logic             base_is_pc,
    input  logic [W-1:0]     reg_opnd,
    input  logic [IMM_W-1:0] imm_val,
    input  logic             use_imm,
    input  logic             carry_in,
    output logic [W-1:0]     add_x,
    output logic [W-1:0]     add_y,
    output logic             add_ci
);
    localparam int ALIGN_BITS = 2;
    localparam int PAD_W      = W - IMM_W;

    logic [W-1:0] base_al;
    logic [W-1:0] opnd2;
    logic         imm_ok;

    always_comb begin
        base_al = base_val;
        if (base_is_pc) begin
            base_al[ALIGN_BITS-1:0] = '0;
        end
        imm_ok = use_imm && ((op_sel == OP_ADD) || (op_sel == OP_SUB));
        opnd2  = imm_ok ? {{PAD_W{1'b0}}, imm_val} : reg_opnd;
    end

    always_comb begin
        unique case (op_sel)
            OP_ADC: begin add_x = base_al; add_y = opnd2;    add_ci = carry_in; end
            OP_SUB: begin add_x = base_al; add_y = ~opnd2;   add_ci = 1'b1;     end
            OP_SBC: begin add_x = base_al; add_y = ~opnd2;   add_ci = carry_in; end
            OP_RSB: begin add_x = opnd2;   add_y = ~base_al; add_ci = 1'b1;     end
            default: begin add_x = base_al; add_y = opnd2;   add_ci = 1'b0;     end
        endcase
    end
endmodule

// File: rtl/addsub_adder.sv
module addsub_adder #(
    parameter int W = 32
) (
    input  logic [W-1:0] add_x,
    input  logic [W-1:0] add_y,
    input  logic         add_ci,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);
    logic [W:0] wide;

    always_comb begin
        wide = {1'b0, add_x} + {1'b0, add_y} + {{W{1'b0}}, add_ci};
        sum  = wide[W-1:0];
        cout = wide[W];
        ovf  = (add_x[W-1] == add_y[W-1]) && (wide[W-1] != add_x[W-1]);
    end
endmodule

// File: rtl/addsub_unit.sv
module addsub_unit
    import addsub_pkg::*;
#(
    parameter int W     = 32,
    parameter int IMM_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       op_sel,
    input  logic [W-1:0]     base_val,
    input  logic             base_is_pc,
    input  logic [W-1:0]     reg_opnd,
    input  logic [IMM_W-1:0] imm12,
    input  logic             use_imm,
    input  logic             carry_in,
    input  logic             set_flags,
    output logic [W-1:0]     result_q,
    output logic             flag_n,
    output logic             flag_z,
    output logic             flag_c,
    output logic             flag_v
);
    logic [W-1:0] add_x, add_y, sum;
    logic         add_ci, cout, ovf;
    logic         flag_wr;
    nzcv_t        flags_d, flags_q;

    addsub_operand_prep #(.W(W), .IMM_W(IMM_W)) u_prep (
        .op_sel     (op_sel),
        .base_val   (base_val),
        .base_is_pc (base_is_pc),
        .reg_opnd   (reg_opnd),
        .imm_val    (imm12),
        .use_imm    (use_imm),
        .carry_in   (carry_in),
        .add_x      (add_x),
        .add_y      (add_y),
        .add_ci     (add_ci)
    );

    addsub_adder #(.W(W)) u_add (
        .add_x  (add_x),
        .add_y  (add_y),
        .add_ci (add_ci),
        .sum    (sum),
        .cout   (cout),
        .ovf    (ovf)
    );

    always_comb begin
        flag_wr   = set_flags && !base_is_pc;
        flags_d.n = sum[W-1];
        flags_d.z = ~|sum;
        flags_d.c = cout;
        flags_d.v = ovf;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result_q <= '0;
        end else begin
            result_q <= sum;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
        end else if (flag_wr) begin
            flags_q <= flags_d;
        end
    end

    assign flag_n = flags_q.n;
    assign flag_z = flags_q.z;
    assign flag_c = flags_q.c;
    assign flag_v = flags_q.v;
endmodule

// File: rtl/addsub_unit_chk.sv
module addsub_unit_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic [2:0]   op_sel,
    input logic [W-1:0] base_val,
    input logic         base_is_pc,
    input logic [W-1:0] reg_opnd,
    input logic         use_imm,
    input logic         set_flags,
    input logic [W-1:0] result_q,
    input logic         flag_n,
    input logic         flag_z,
    input logic         flag_c,
    input logic         flag_v
);
    // R11
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (result_q == '0) && ({flag_n, flag_z, flag_c, flag_v} == 4'b0));

    // R7
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !set_flags |=> $stable({flag_n, flag_z, flag_c, flag_v}));

    // R8
    pc_flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        base_is_pc |=> $stable({flag_n, flag_z, flag_c, flag_v}));

    // R9
    nz_match_chk: assert property (@(posedge clk) disable iff (rst)
        (set_flags && !base_is_pc) |=> (flag_n == result_q[W-1]) && (flag_z == (result_q == '0)));

    // R1
    add_result_chk: assert property (@(posedge clk) disable iff (rst)
        (op_sel == 3'd0 && !base_is_pc && !use_imm) |=> result_q == $past(base_val + reg_opnd));

    // R5
    rsb_result_chk: assert property (@(posedge clk) disable iff (rst)
        (op_sel == 3'd4 && !base_is_pc) |=> result_q == $past(reg_opnd - base_val));

    // R8
    pc_align_chk: assert property (@(posedge clk) disable iff (rst)
        (op_sel == 3'd0 && base_is_pc && !use_imm) |=>
            result_q == $past({base_val[W-1:2], 2'b00} + reg_opnd));
endmodule

bind addsub_unit addsub_unit_chk #(.W(W)) u_chk (.*);

// File: tb/sim_addsub_unit.sv
`timescale 1ns/1ps
module sim_addsub_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  op_sel = '0;
    logic [31:0] base_val = '0;
    logic        base_is_pc = 1'b0;
    logic [31:0] reg_opnd = '0;
    logic [11:0] imm12 = '0;
    logic        use_imm = 1'b0;
    logic        carry_in = 1'b0;
    logic        set_flags = 1'b0;
    logic [31:0] result_q;
    logic        flag_n, flag_z, flag_c, flag_v;

    int checks = 0;
    int fails  = 0;
    logic [3:0] exp_flags = 4'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    addsub_unit u0 (.*);

    typedef struct packed {
        logic [2:0]  op;
        logic [31:0] a;
        logic [31:0] b;
        logic        ci;
    } vec_t;

    localparam vec_t VECS [20] = '{
        '{3'd0, 32'h0000_0000, 32'h0000_0000, 1'b0},
        '{3'd0, 32'h7FFF_FFFF, 32'h0000_0001, 1'b0},
        '{3'd0, 32'hFFFF_FFFF, 32'h0000_0001, 1'b0},
        '{3'd0, 32'h8000_0000, 32'h8000_0000, 1'b0},
        '{3'd1, 32'hFFFF_FFFF, 32'h0000_0000, 1'b1},
        '{3'd1, 32'h7FFF_FFFF, 32'h0000_0000, 1'b1},
        '{3'd1, 32'h1234_5678, 32'h0000_0001, 1'b0},
        '{3'd2, 32'h0000_0000, 32'h0000_0001, 1'b0},
        '{3'd2, 32'h8000_0000, 32'h0000_0001, 1'b0},
        '{3'd2, 32'h0000_0005, 32'h0000_0005, 1'b0},
        '{3'd2, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 1'b0},
        '{3'd3, 32'h0000_0005, 32'h0000_0005, 1'b0},
        '{3'd3, 32'h0000_0005, 32'h0000_0005, 1'b1},
        '{3'd3, 32'h8000_0000, 32'h0000_0000, 1'b0},
        '{3'd3, 32'h0000_0000, 32'hFFFF_FFFF, 1'b1},
        '{3'd4, 32'h0000_0001, 32'h0000_0000, 1'b0},
        '{3'd4, 32'h0000_0003, 32'h0000_0010, 1'b0},
        '{3'd4, 32'h8000_0000, 32'h0000_0000, 1'b1},
        '{3'd4, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 1'b0},
        '{3'd6, 32'h0000_0010, 32'h0000_0020, 1'b0}
    };

    function automatic logic [35:0] ref_calc(input logic [2:0] op, input logic [31:0] a,
            input logic pc, input logic [31:0] b_reg, input logic [11:0] imm,
            input logic ui, input logic ci);
        logic [31:0] ae, be, res;
        longint sa, sb, s;
        logic c, v;
        ae = pc ? (a & 32'hFFFF_FFFC) : a;
        be = (ui && (op == 3'd0 || op == 3'd2)) ? {20'd0, imm} : b_reg;
        sa = longint'($signed(ae));
        sb = longint'($signed(be));
        case (op)
            3'd1: begin s = sa + sb + (ci ? 1 : 0); c = ({1'b0, ae} + {1'b0, be} + {32'd0, ci}) > 33'h0_FFFF_FFFF; end
            3'd2: begin s = sa - sb; c = (ae >= be); end
            3'd3: begin s = sa - sb - (ci ? 0 : 1); c = ({1'b0, ae} >= ({1'b0, be} + {32'd0, !ci})); end
            3'd4: begin s = sb - sa; c = (be >= ae); end
            default: begin s = sa + sb; c = ({1'b0, ae} + {1'b0, be}) > 33'h0_FFFF_FFFF; end
        endcase
        res = s[31:0];
        v = (s > 64'sd2147483647) || (s < -64'sd2147483648);
        return {res, res[31], (res == 32'd0), c, v};
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_op(input string req, input logic [2:0] op, input logic [31:0] a,
            input logic pc, input logic [31:0] b, input logic [11:0] imm, input logic ui,
            input logic ci, input logic s);
        logic [35:0] r;
        @(negedge clk);
        op_sel = op; base_val = a; base_is_pc = pc; reg_opnd = b;
        imm12 = imm; use_imm = ui; carry_in = ci; set_flags = s;
        r = ref_calc(op, a, pc, b, imm, ui, ci);
        @(posedge clk);
        #1;
        if (s && !pc) exp_flags = r[3:0];
        check({req, " result"}, {32'd0, result_q}, {32'd0, r[35:4]});
        check({req, " flags"}, {60'd0, flag_n, flag_z, flag_c, flag_v}, {60'd0, exp_flags});
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] lo, hi;
        logic [63:0] ea, eb;
        repeat (3) @(posedge clk);
        #1;
        check("R11 reset", {27'd0, result_q, flag_n, flag_z, flag_c, flag_v}, 64'd0);
        @(negedge clk);
        rst = 1'b0;

        // R1 R2 R3 R4 R5 R9 R10 R13: vector table walk
        for (int i = 0; i < 20; i++) begin
            do_op("R1-R5/R9/R10/R13 table", VECS[i].op, VECS[i].a, 1'b0, VECS[i].b, 12'd0,
                  1'b0, VECS[i].ci, 1'b1);
        end

        // R3 R5: random operands per op
        for (int i = 0; i < 40; i++) begin
            do_op("R3_R5 random", 3'(i % 5), $urandom, 1'b0, $urandom, 12'd0, 1'b0,
                  1'($urandom), 1'b1);
        end

        // R6: immediate on add and sub, ignored on add-with-carry and reverse sub
        do_op("R6 imm add", 3'd0, 32'h0000_1000, 1'b0, 32'hDEAD_BEEF, 12'hFFF, 1'b1, 1'b0, 1'b1);
        check("R6 imm add value", {32'd0, result_q}, 64'h0000_1FFF);
        do_op("R6 imm sub", 3'd2, 32'h0000_0000, 1'b0, 32'h1, 12'h801, 1'b1, 1'b0, 1'b1);
        check("R6 imm sub value", {32'd0, result_q}, 64'hFFFF_F7FF);
        do_op("R6 imm ignored adc", 3'd1, 32'h10, 1'b0, 32'h20, 12'h7, 1'b1, 1'b0, 1'b1);
        check("R6 ignored value", {32'd0, result_q}, 64'h30);
        do_op("R6 imm ignored rsb", 3'd4, 32'h10, 1'b0, 32'h20, 12'h7, 1'b1, 1'b0, 1'b1);

        // R7: flags hold when set_flags is low
        do_op("R7 setup", 3'd2, 32'h0, 1'b0, 32'h1, 12'd0, 1'b0, 1'b0, 1'b1);
        do_op("R7 hold", 3'd0, 32'h1, 1'b0, 32'h1, 12'd0, 1'b0, 1'b0, 1'b0);
        check("R7 flags held", {60'd0, flag_n, flag_z, flag_c, flag_v}, 64'b1000);

        // R8: pc base aligned, flag write suppressed
        do_op("R8 pc add", 3'd0, 32'h0000_1003, 1'b1, 32'h0000_0000, 12'd0, 1'b0, 1'b0, 1'b1);
        check("R8 pc aligned value", {32'd0, result_q}, 64'h1000);
        check("R8 pc flags held", {60'd0, flag_n, flag_z, flag_c, flag_v}, 64'b1000);
        do_op("R8 pc sub imm", 3'd2, 32'h0000_2006, 1'b1, 32'h0, 12'h004, 1'b1, 1'b0, 1'b1);
        check("R8 pc sub value", {32'd0, result_q}, 64'h2000);

        // R12: 64-bit add chain
        ea = 64'h0000_0001_FFFF_FFFF;
        eb = 64'h0000_0002_0000_0001;
        do_op("R12 add lo", 3'd0, ea[31:0], 1'b0, eb[31:0], 12'd0, 1'b0, 1'b0, 1'b1);
        lo = result_q;
        do_op("R12 adc hi", 3'd1, ea[63:32], 1'b0, eb[63:32], 12'd0, 1'b0, flag_c, 1'b1);
        hi = result_q;
        check("R12 add chain", {hi, lo}, ea + eb);
        do_op("R12 sub lo", 3'd2, ea[31:0], 1'b0, eb[31:0], 12'd0, 1'b0, 1'b0, 1'b1);
        lo = result_q;
        do_op("R12 sbc hi", 3'd3, ea[63:32], 1'b0, eb[63:32], 12'd0, 1'b0, flag_c, 1'b1);
        hi = result_q;
        check("R12 sub chain", {hi, lo}, ea - eb);
        do_op("R12 sub lo b", 3'd2, eb[31:0], 1'b0, ea[31:0], 12'd0, 1'b0, 1'b0, 1'b1);
        lo = result_q;
        do_op("R12 sbc hi b", 3'd3, eb[63:32], 1'b0, ea[63:32], 12'd0, 1'b0, flag_c, 1'b1);
        hi = result_q;
        check("R12 sub chain borrow", {hi, lo}, eb - ea);

        // R13: opcode 7 acts as add
        do_op("R13 op7", 3'd7, 32'h5, 1'b0, 32'h7, 12'd0, 1'b0, 1'b1, 1'b1);
        check("R13 op7 value", {32'd0, result_q}, 64'hC);

        // R11: reset mid-run
        do_op("R11 pre", 3'd2, 32'h0, 1'b0, 32'h1, 12'd0, 1'b0, 1'b0, 1'b1);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check("R11 mid-run reset", {27'd0, result_q, flag_n, flag_z, flag_c, flag_v}, 64'd0);
        @(negedge clk);
        rst = 1'b0;

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule